// File: doc/BRIEF.md
# Scalar Load/Store Request Former

This block converts one scalar memory instruction into a memory request. It takes the instruction word and the two operand register values and, one clock later, presents a request. The request holds the effective address, the store data moved into its byte lanes, a write byte-lane mask, a read extension mask, the right-shift amount used to align loaded data, the load destination register and a store flag. Signed and unsigned byte and halfword loads, word loads, and byte, halfword and word stores are all handled by the same shift formula. The access size sets the shift amount, and one mask chosen by the request index gives either sign or zero extension.

A load-data aligner sits beside the request path. It keeps the shift, the mask and the destination of the most recent load. When the memory returns a word, it shifts that word right arithmetically, masks it, and presents the aligned value and its destination one clock later. The data memory itself lies outside the block. Addresses are never checked for alignment. An address whose low bits are not zero is passed through unchanged and no fault is raised.

Top module: `smrf_top`

## Requirements
- R1: While `rst` is high at a clock edge, `req_valid` and `wb_valid` are low after that edge and every request field reads zero.
- R2: For an instruction accepted with `issue_valid` high, `req_valid` is high for exactly the next cycle. In that cycle `req_addr` equals `rs_val` plus the sign-extended `issue_instr[15:0]`, with wraparound modulo 2^32 and no alignment check.
- R3: `req_store` equals instruction bit 29. The access size is instruction bits [27:26] (0 byte, 1 half, 3 word), and `req_rshift` is (3 - size) × 8.
- R4: For a store, `req_wdata` is `rt_val` shifted left by `req_rshift` and `req_wmask` is all ones shifted left by `req_rshift`. For a load, `req_wmask` is zero.
- R5: `req_rmask` follows the request index `issue_instr[28:26]`: all ones for index 0, 1, 3 and 7; 0x000000FF for index 4; 0x0000FFFF for index 5; zero for index 2 and 6.
- R6: `req_dest` is `issue_instr[20:16]` for a load and 0 for a store.
- R7: One cycle after `mem_rvalid` is high, `wb_valid` is high and `wb_data` equals `mem_rdata` shifted right arithmetically by the last load's shift and ANDed with that load's read mask. `wb_dest` is that load's destination.
- R8: When a return and a new load are accepted in the same cycle, the return is aligned with the earlier load's context, and the new context applies only to later returns. A store leaves the load context unchanged.
- R9: In a cycle with `issue_valid` low, `req_valid` goes low and the request fields keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction presented this cycle |
| issue_instr | input | 32 | Instruction word |
| rs_val | input | 32 | Base register value |
| rt_val | input | 32 | Data register value (store source) |
| req_valid | output | 1 | Request valid for one cycle |
| req_addr | output | 32 | Effective address |
| req_store | output | 1 | Request is a store |
| req_wdata | output | 32 | Lane-aligned store data |
| req_wmask | output | 32 | Write mask, zero for loads |
| req_rmask | output | 32 | Read extension mask |
| req_rshift | output | 5 | Load alignment right-shift amount |
| req_dest | output | 5 | Load destination register, 0 for stores |
| mem_rvalid | input | 1 | Memory returns a word this cycle |
| mem_rdata | input | 32 | Returned memory word |
| wb_valid | output | 1 | Aligned load data valid |
| wb_data | output | 32 | Aligned, extended load data |
| wb_dest | output | 5 | Destination of the aligned data |

## Verification
The request path and the aligner can both act in one cycle. A new load can be accepted while a word for the previous load is being returned. The bench provokes this by driving `issue_valid` and `mem_rvalid` together, first with two loads of different extension and then with a store in between. The scoreboard predicts the returned value from the older load's shift and mask, and it predicts every later return from the newer load's context.

// File: rtl/smrf_pkg.sv
package smrf_pkg;
    localparam int DATA_W = 32;
    localparam int REG_W  = 5;
    localparam int IMM_W  = 16;
    localparam int SH_W   = $clog2(DATA_W);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_RSVD = 2'd2,
        SZ_WORD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic [DATA_W-1:0] addr;
        logic              store;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] wmask;
        logic [DATA_W-1:0] rmask;
        logic [SH_W-1:0]   rshift;
        logic [REG_W-1:0]  dest;
    } mem_req_t;

    typedef struct packed {
        logic [SH_W-1:0]   shift;
        logic [DATA_W-1:0] mask;
        logic [REG_W-1:0]  dest;
    } load_ctx_t;

    // Lane shift: the smaller the access, the further it moves.
    function automatic logic [SH_W-1:0] lane_shift(acc_size_e sz);
        logic [1:0] gap;
        gap = 2'd3 - 2'(sz);
        return SH_W'({gap, 3'b000});
    endfunction

    // Extension mask chosen by the three-bit request index.
    function automatic logic [DATA_W-1:0] ext_mask(logic [2:0] idx);
        logic [DATA_W-1:0] m;
        unique case (idx)
            3'd4:          m = DATA_W'(8'hFF);
            3'd5:          m = DATA_W'(16'hFFFF);
            3'd2, 3'd6:    m = '0;
            default:       m = '1;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/smrf_decode.sv
module smrf_decode
    import smrf_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int RW = REG_W,
    parameter int IW = IMM_W
) (
    input  logic [31:0]  instr,
    input  logic [DW-1:0] rs_val,
    input  logic [DW-1:0] rt_val,
    output mem_req_t      req
);
    localparam int STORE_BIT = 29;
    localparam int IDX_LSB   = 26;
    localparam int RT_LSB    = 16;

    logic [2:0]      idx;
    acc_size_e       sz;
    logic [SH_W-1:0] sh;
    logic            is_store;
    logic [DW-1:0]   imm_ext;

    always_comb begin
        idx      = instr[IDX_LSB +: 3];
        sz       = acc_size_e'(idx[1:0]);
        sh       = lane_shift(sz);
        is_store = instr[STORE_BIT];
        imm_ext  = {{(DW-IW){instr[IW-1]}}, instr[IW-1:0]};

        req.addr   = rs_val + imm_ext;
        req.store  = is_store;
        req.wdata  = rt_val << sh;
        req.wmask  = is_store ? ({DW{1'b1}} << sh) : '0;
        req.rmask  = ext_mask(idx);
        req.rshift = sh;
        req.dest   = is_store ? '0 : instr[RT_LSB +: RW];
    end
endmodule

// File: rtl/smrf_req_stage.sv
module smrf_req_stage
    import smrf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load_en,
    input  mem_req_t req_in,
    output logic     req_valid,
    output mem_req_t req_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid <= 1'b0;
            req_out   <= '0;
        end else begin
            req_valid <= load_en;
            if (load_en) req_out <= req_in;
        end
    end
endmodule

// File: rtl/smrf_align.sv
module smrf_align
    import smrf_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctx_we,
    input  load_ctx_t     ctx_in,
    input  logic          rvalid,
    input  logic [DW-1:0] rdata,
    output logic          wb_valid,
    output logic [DW-1:0] wb_data,
    output logic [REG_W-1:0] wb_dest
);
    load_ctx_t     ctx_q;
    logic [DW-1:0] aligned;

    always_comb begin
        aligned = DW'($signed(rdata) >>> ctx_q.shift) & ctx_q.mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q    <= '0;
            wb_valid <= 1'b0;
            wb_data  <= '0;
            wb_dest  <= '0;
        end else begin
            wb_valid <= rvalid;
            if (rvalid) begin
                wb_data <= aligned;
                wb_dest <= ctx_q.dest;
            end
            if (ctx_we) ctx_q <= ctx_in;
        end
    end
endmodule

// File: rtl/smrf_top.sv
module smrf_top
    import smrf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    input  logic [31:0]       issue_instr,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] rt_val,
    output logic              req_valid,
    output logic [DATA_W-1:0] req_addr,
    output logic              req_store,
    output logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] req_wmask,
    output logic [DATA_W-1:0] req_rmask,
    output logic [SH_W-1:0]   req_rshift,
    output logic [REG_W-1:0]  req_dest,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              wb_valid,
    output logic [DATA_W-1:0] wb_data,
    output logic [REG_W-1:0]  wb_dest
);
    mem_req_t  dec_req;
    mem_req_t  cur_req;
    load_ctx_t new_ctx;
    logic      ctx_we;

    smrf_decode u_decode (
        .instr  (issue_instr),
        .rs_val (rs_val),
        .rt_val (rt_val),
        .req    (dec_req)
    );

    smrf_req_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .load_en   (issue_valid),
        .req_in    (dec_req),
        .req_valid (req_valid),
        .req_out   (cur_req)
    );

    always_comb begin
        ctx_we        = issue_valid && !dec_req.store;
        new_ctx.shift = dec_req.rshift;
        new_ctx.mask  = dec_req.rmask;
        new_ctx.dest  = dec_req.dest;
    end

    smrf_align u_align (
        .clk      (clk),
        .rst      (rst),
        .ctx_we   (ctx_we),
        .ctx_in   (new_ctx),
        .rvalid   (mem_rvalid),
        .rdata    (mem_rdata),
        .wb_valid (wb_valid),
        .wb_data  (wb_data),
        .wb_dest  (wb_dest)
    );

    assign req_addr   = cur_req.addr;
    assign req_store  = cur_req.store;
    assign req_wdata  = cur_req.wdata;
    assign req_wmask  = cur_req.wmask;
    assign req_rmask  = cur_req.rmask;
    assign req_rshift = cur_req.rshift;
    assign req_dest   = cur_req.dest;
endmodule

// File: rtl/smrf_checker.sv
module smrf_checker
    import smrf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              issue_valid,
    input logic              req_valid,
    input logic [DATA_W-1:0] req_addr,
    input logic              req_store,
    input logic [DATA_W-1:0] req_wmask,
    input logic [SH_W-1:0]   req_rshift,
    input logic [REG_W-1:0]  req_dest,
    input logic              mem_rvalid,
    input logic              wb_valid
);
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!req_valid && !wb_valid));

    p_req_follows_issue_r2: assert property (@(posedge clk) disable iff (rst)
        issue_valid |=> req_valid);

    p_shift_byte_step_r3: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_rshift[2:0] == 3'd0));

    p_load_no_write_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_store) |-> (req_wmask == '0));

    p_store_dest_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_store) |-> (req_dest == '0));

    p_return_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        mem_rvalid |=> wb_valid);

    p_idle_drops_valid_r9: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |=> !req_valid);

    p_idle_holds_addr_r9: assert property (@(posedge clk) disable iff (rst)
        (!issue_valid && !$past(rst)) |=> $stable(req_addr));
endmodule

bind smrf_top smrf_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .issue_valid (issue_valid),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_store   (req_store),
    .req_wmask   (req_wmask),
    .req_rshift  (req_rshift),
    .req_dest    (req_dest),
    .mem_rvalid  (mem_rvalid),
    .wb_valid    (wb_valid)
);

// File: tb/smrf_top_bench.sv
module smrf_top_bench;
    import smrf_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic [31:0] issue_instr = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic        req_valid;
    logic [31:0] req_addr;
    logic        req_store;
    logic [31:0] req_wdata;
    logic [31:0] req_wmask;
    logic [31:0] req_rmask;
    logic [4:0]  req_rshift;
    logic [4:0]  req_dest;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        wb_valid;
    logic [31:0] wb_data;
    logic [4:0]  wb_dest;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    smrf_top u_smrf_top (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_instr(issue_instr),
        .rs_val(rs_val), .rt_val(rt_val), .req_valid(req_valid), .req_addr(req_addr),
        .req_store(req_store), .req_wdata(req_wdata), .req_wmask(req_wmask),
        .req_rmask(req_rmask), .req_rshift(req_rshift), .req_dest(req_dest),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .wb_valid(wb_valid),
        .wb_data(wb_data), .wb_dest(wb_dest)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        store;
        logic [31:0] wdata;
        logic [31:0] wmask;
        logic [31:0] rmask;
        logic [4:0]  rshift;
        logic [4:0]  dest;
    } exp_req_t;

    typedef struct packed {
        logic [31:0] data;
        logic [4:0]  dest;
    } exp_wb_t;

    exp_req_t req_q[$];
    exp_wb_t  wb_q[$];
    exp_req_t last_req;

    // Bench copy of the load context (R8): shift, mask, destination.
    logic [4:0]  m_shift = '0;
    logic [31:0] m_mask  = '0;
    logic [4:0]  m_dest  = '0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic exp_req_t model_req(input logic [31:0] ins, input logic [31:0] rs,
                                           input logic [31:0] rt);
        exp_req_t e;
        logic [1:0] sz;
        sz       = ins[27:26];
        e.addr   = rs + {{16{ins[15]}}, ins[15:0]};
        e.store  = ins[29];
        case (sz)
            2'd0: e.rshift = 5'd24;
            2'd1: e.rshift = 5'd16;
            2'd2: e.rshift = 5'd8;
            default: e.rshift = 5'd0;
        endcase
        e.wdata  = rt << e.rshift;
        e.wmask  = ins[29] ? (32'hFFFF_FFFF << e.rshift) : 32'h0;
        case (ins[28:26])
            3'd4: e.rmask = 32'h0000_00FF;
            3'd5: e.rmask = 32'h0000_FFFF;
            3'd2, 3'd6: e.rmask = 32'h0;
            default: e.rmask = 32'hFFFF_FFFF;
        endcase
        e.dest   = ins[29] ? 5'd0 : ins[20:16];
        return e;
    endfunction

    function automatic logic [31:0] mk(input bit st, input logic [2:0] idx,
                                       input logic [4:0] rt, input logic [15:0] imm);
        return {2'b10, st, idx, 5'd3, rt, imm};
    endfunction

    // Driver: one cycle of stimulus; expectations pushed before the edge.
    task automatic drive(input bit iv, input logic [31:0] ins, input logic [31:0] rs,
                         input logic [31:0] rt, input bit rv, input logic [31:0] rd);
        exp_req_t e;
        exp_wb_t  w;
        @(negedge clk);
        issue_valid = iv; issue_instr = ins; rs_val = rs; rt_val = rt;
        mem_rvalid  = rv; mem_rdata = rd;
        if (rv) begin
            w.data = 32'($signed(rd) >>> m_shift) & m_mask;
            w.dest = m_dest;
            wb_q.push_back(w);
        end
        if (iv) begin
            e = model_req(ins, rs, rt);
            req_q.push_back(e);
            if (!e.store) begin
                m_shift = e.rshift; m_mask = e.rmask; m_dest = e.dest;
            end
        end
    endtask

    task automatic idle();
        drive(1'b0, '0, '0, '0, 1'b0, '0);
    endtask

    // Monitor: samples 2 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst) begin
                if (req_valid) begin
                    if (req_q.size() == 0) begin
                        check(1'b0, "R2 unexpected request", 64'(req_valid), 64'd0);
                    end else begin
                        exp_req_t e;
                        e = req_q.pop_front();
                        last_req = e;
                        check(req_addr == e.addr, "R2 address", 64'(req_addr), 64'(e.addr));
                        check(req_store == e.store && req_rshift == e.rshift, "R3 store/shift",
                              64'({req_store, req_rshift}), 64'({e.store, e.rshift}));
                        check(req_wdata == e.wdata && req_wmask == e.wmask, "R4 wdata/wmask",
                              {req_wdata, req_wmask}, {e.wdata, e.wmask});
                        check(req_rmask == e.rmask, "R5 read mask", 64'(req_rmask), 64'(e.rmask));
                        check(req_dest == e.dest, "R6 destination", 64'(req_dest), 64'(e.dest));
                    end
                end else if (req_q.size() != 0) begin
                    check(1'b0, "R2 missing request", 64'(req_valid), 64'd1);
                    void'(req_q.pop_front());
                end
                if (wb_valid) begin
                    if (wb_q.size() == 0) begin
                        check(1'b0, "R7 unexpected writeback", 64'(wb_valid), 64'd0);
                    end else begin
                        exp_wb_t w;
                        w = wb_q.pop_front();
                        check(wb_data == w.data && wb_dest == w.dest, "R7/R8 aligned data",
                              64'({wb_dest, wb_data}), 64'({w.dest, w.data}));
                    end
                end else if (wb_q.size() != 0) begin
                    check(1'b0, "R7 missing writeback", 64'(wb_valid), 64'd1);
                    void'(wb_q.pop_front());
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!req_valid && !wb_valid && req_addr == 0 && req_wmask == 0 && req_dest == 0,
              "R1 reset state", 64'({req_valid, wb_valid, req_addr}), 64'd0);
        rst = 1'b0;

        // Loads of every index, each followed by a return (R3, R5, R6, R7).
        drive(1, mk(0, 3'd0, 5'd4, 16'h0010), 32'h0000_0100, 32'h0, 0, '0);
        drive(0, '0, '0, '0, 1, 32'h80AA_BBCC);
        drive(1, mk(0, 3'd4, 5'd5, 16'hFFFC), 32'h0000_0100, 32'h0, 0, '0);
        drive(0, '0, '0, '0, 1, 32'h80AA_BBCC);
        drive(1, mk(0, 3'd1, 5'd6, 16'h0002), 32'h0000_0200, 32'h0, 0, '0);
        drive(0, '0, '0, '0, 1, 32'h8001_1234);
        drive(1, mk(0, 3'd5, 5'd7, 16'h0002), 32'h0000_0200, 32'h0, 0, '0);
        drive(0, '0, '0, '0, 1, 32'h8001_1234);
        drive(1, mk(0, 3'd3, 5'd8, 16'h0000), 32'h0000_0300, 32'h0, 0, '0);
        drive(0, '0, '0, '0, 1, 32'hDEAD_BEEF);
        drive(1, mk(0, 3'd7, 5'd9, 16'h0000), 32'h0000_0300, 32'h0, 0, '0);
        drive(0, '0, '0, '0, 1, 32'hCAFE_F00D);
        drive(1, mk(0, 3'd2, 5'd10, 16'h0000), 32'h0, 32'h0, 0, '0);
        drive(0, '0, '0, '0, 1, 32'hFFFF_FFFF);
        drive(1, mk(0, 3'd6, 5'd11, 16'h0000), 32'h0, 32'h0, 0, '0);
        drive(0, '0, '0, '0, 1, 32'h1234_5678);

        // Stores of byte, half, word; misaligned and wrapping addresses (R2, R4, R6).
        drive(1, mk(1, 3'd0, 5'd12, 16'h0003), 32'h0000_0401, 32'h0000_00A5, 0, '0);
        drive(1, mk(1, 3'd1, 5'd13, 16'h8000), 32'h0000_0001, 32'h1234_BEEF, 0, '0);
        drive(1, mk(1, 3'd3, 5'd14, 16'h0001), 32'hFFFF_FFFF, 32'h0BAD_CAFE, 0, '0);
        idle();

        // R9: idle cycles hold the last request fields.
        idle();
        @(posedge clk); #2;
        check(!req_valid && req_addr == last_req.addr && req_wdata == last_req.wdata,
              "R9 hold while idle", 64'({req_valid, req_addr}), 64'(last_req.addr));

        // R8: return and new load in one cycle; a store in between keeps context.
        drive(1, mk(0, 3'd0, 5'd15, 16'h0000), 32'h10, 32'h0, 0, '0);
        drive(1, mk(0, 3'd5, 5'd16, 16'h0000), 32'h20, 32'h0, 1, 32'hF0F0_0F0F);
        drive(1, mk(1, 3'd0, 5'd17, 16'h0000), 32'h30, 32'h55, 1, 32'h9876_5432);
        drive(0, '0, '0, '0, 1, 32'h8421_FFFF);
        drive(1, mk(0, 3'd4, 5'd18, 16'h0004), 32'h40, 32'h0, 1, 32'h7F00_0000);
        drive(0, '0, '0, '0, 1, 32'hAB00_0000);
        idle();
        idle();

        // R1: reset mid-stream clears outputs.
        drive(1, mk(0, 3'd3, 5'd19, 16'h0000), 32'h50, 32'h0, 1, 32'h1);
        @(negedge clk);
        rst = 1'b1; issue_valid = 1'b0; mem_rvalid = 1'b0;
        req_q.delete(); wb_q.delete();
        @(posedge clk); #2;
        check(!req_valid && !wb_valid && req_addr == 0 && req_rmask == 0,
              "R1 reset mid-stream", 64'({req_valid, wb_valid, req_addr}), 64'd0);
        m_shift = '0; m_mask = '0; m_dest = '0;
        @(negedge clk);
        rst = 1'b0;
        drive(0, '0, '0, '0, 1, 32'hFFFF_FFFF);
        idle();
        idle();

        check(req_q.size() == 0 && wb_q.size() == 0, "R2/R7 scoreboard drained",
              64'(req_q.size() + wb_q.size()), 64'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule